// File: doc/BRIEF.md
# CAN Fault Confinement and Error Interrupt Unit

This unit follows the fault-confinement state of a CAN node. The protocol engine reports counter changes and error-cause pulses. The unit keeps the 8-bit transmit and receive error counters and derives one of four states from them: error-active, warning, error-passive or bus-off. It holds a 32-bit status word in which every error cause and every state change is a sticky, write-one-to-clear flag. It also raises masked interrupt flags that go to one of two interrupt lines.

The protocol engine drives an increment amount and a decrement pulse for each counter, so it chooses its own weighting rules. The unit enters bus-off when the transmit count would pass 255. From bus-off there are two ways back to error-active. With auto-bus-on set, the node returns after 128 idle-sequence pulses. Otherwise it stays in bus-off until software pulses the re-initialise input. Software configures the interrupt mask word, reads the status and flag words, and clears flags by driving ones on the clear vectors for one cycle.

Top module: `can_fault_unit`

## Requirements
- R1: Reset state: both counters are 0, `state_o` is 0, all status bits and flag bits are 0, and both interrupt lines are low.
- R2: Counter arithmetic, which applies outside bus-off. Each cycle a counter becomes count + increment − decrement, where the decrement pulse counts as 1 and has no effect when the sum is 0. The receive counter saturates at 255. `state_o` encodes the state as 0 for active, 1 for warning, 2 for passive and 3 for bus-off.
- R3: The warning state holds when either counter is above 96. When the warning state begins, status bit 16 sets.
- R4: The passive state holds when either counter is above 127. When the passive state begins, status bit 17 sets.
- R5: When the transmit sum would exceed 255, the node enters bus-off. The transmit counter then holds 255 and status bit 18 sets. While in bus-off, both counters ignore their inputs.
- R6: Error-cause pulses `err_ev_i[5:0]` set sticky status bits 19+i: bit 24 form, bit 23 bit error, bit 22 stuck-dominant, bit 21 CRC, bit 20 stuff, bit 19 acknowledge.
- R7: A 1 on a bit of `stat_clr_i` clears that status bit for one cycle. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: Flag bits 8 (warning), 9 (passive) and 10 (bus-off) set on the same transitions as status bits 16 to 18, but only when mask bits 8, 9 and 10 respectively are 1. A flag goes to `gif1_o` when mask bit 2 is 1 and to `gif0_o` otherwise. A 1 on the matching bit of the clear vector clears it.
- R9: `irq0_o` is high when mask bit 0 is 1 and any `gif0_o` flag is set. `irq1_o` is high when mask bit 1 is 1 and any `gif1_o` flag is set.
- R10: When a single update enters warning, passive and bus-off together, status bits 16 to 18 and all three enabled flags set in the same cycle.
- R11: In bus-off with auto-bus-on set, the 128th consecutive `recess_seq_i` pulse returns the node to active with both counters at 0. The 127th pulse does not.
- R12: In bus-off with auto-bus-on clear, the node stays in bus-off no matter how many idle pulses arrive. A `reinit_i` pulse zeroes both counters and returns the node to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tec_inc_i | input | 8 | Amount added to the transmit counter this cycle |
| tec_dec_i | input | 1 | Subtract one from the transmit counter |
| rec_inc_i | input | 8 | Amount added to the receive counter this cycle |
| rec_dec_i | input | 1 | Subtract one from the receive counter |
| err_ev_i | input | 6 | Error-cause pulses (form, bit, stuck, CRC, stuff, ack from MSB) |
| recess_seq_i | input | 1 | One idle recessive sequence observed |
| auto_bus_on_i | input | 1 | Allow automatic bus-off recovery |
| reinit_i | input | 1 | Software re-initialisation pulse |
| irq_mask_i | input | 32 | Interrupt mask and line routing word |
| stat_clr_i | input | 32 | Write-one-to-clear for the status word |
| gif0_clr_i | input | 32 | Write-one-to-clear for line 0 flags |
| gif1_clr_i | input | 32 | Write-one-to-clear for line 1 flags |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | Fault-confinement state |
| status_o | output | 32 | Sticky status word |
| gif0_o | output | 32 | Line 0 interrupt flags |
| gif1_o | output | 32 | Line 1 interrupt flags |
| irq0_o | output | 1 | Interrupt line 0 |
| irq1_o | output | 1 | Interrupt line 1 |

## Verification
Two events can fall in the same cycle: a status bit can be set by hardware and cleared by software at once, and the warning, passive and bus-off transitions can all fire together. The first case is provoked by pulsing the acknowledge-error cause on the same edge that `stat_clr_i` clears both that bit and the form-error bit. The result is judged correct when the acknowledge bit survives and the form bit clears. The second case is provoked by raising the transmit counter from 90 by 200 in one cycle. The result is judged correct when status bits 16 to 18 and line 0 flags 8 to 10 all appear on the same sampled cycle, with the transmit counter held at 255.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_EV  = 6;
  localparam int EV_LSB  = 19;  // ack at 19 .. form at 24
  localparam int ST_EW   = 16;
  localparam int ST_EP   = 17;
  localparam int ST_BO   = 18;
  localparam int IF_WARN = 8;
  localparam int IF_PASS = 9;
  localparam int IF_BOFF = 10;
  localparam int MSK_L0  = 0;
  localparam int MSK_L1  = 1;
  localparam int MSK_SEL = 2;

  typedef enum logic [1:0] {
    FS_ACTIVE  = 2'd0,
    FS_WARN    = 2'd1,
    FS_PASSIVE = 2'd2,
    FS_BUSOFF  = 2'd3
  } fault_state_e;
endpackage

// File: rtl/can_err_counters.sv
module can_err_counters #(
  parameter int CNT_W     = 8,
  parameter int RECOV_CNT = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_inc_i,
  input  logic             tec_dec_i,
  input  logic [CNT_W-1:0] rec_inc_i,
  input  logic             rec_dec_i,
  input  logic             recess_seq_i,
  input  logic             auto_bus_on_i,
  input  logic             reinit_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             bus_off_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam int RC_W  = $clog2(RECOV_CNT + 1);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] tec_q, rec_q;
  logic             bo_q;
  logic [RC_W-1:0]  rc_q;
  logic [SUM_W-1:0] tec_sum, rec_sum;
  logic [CNT_W-1:0] rec_sat;
  logic             bo_hit, recov_done;

  always_comb begin
    tec_sum = {1'b0, tec_q} + {1'b0, tec_inc_i};
    if (tec_dec_i && (tec_sum != '0)) tec_sum = tec_sum - SUM_W'(1);
    rec_sum = {1'b0, rec_q} + {1'b0, rec_inc_i};
    if (rec_dec_i && (rec_sum != '0)) rec_sum = rec_sum - SUM_W'(1);
    rec_sat    = rec_sum[CNT_W] ? MAXV : rec_sum[CNT_W-1:0];
    bo_hit     = tec_sum[CNT_W];
    recov_done = bo_q && auto_bus_on_i && recess_seq_i &&
                 (rc_q == RC_W'(RECOV_CNT - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tec_q <= '0;
      rec_q <= '0;
      bo_q  <= 1'b0;
      rc_q  <= '0;
    end else if (reinit_i) begin
      tec_q <= '0;
      rec_q <= '0;
      bo_q  <= 1'b0;
      rc_q  <= '0;
    end else if (bo_q) begin
      if (recov_done) begin
        tec_q <= '0;
        rec_q <= '0;
        bo_q  <= 1'b0;
        rc_q  <= '0;
      end else if (!auto_bus_on_i) begin
        rc_q <= '0;
      end else if (recess_seq_i) begin
        rc_q <= rc_q + RC_W'(1);
      end
    end else begin
      tec_q <= bo_hit ? MAXV : tec_sum[CNT_W-1:0];
      rec_q <= rec_sat;
      bo_q  <= bo_hit;
      rc_q  <= '0;
    end
  end

  assign tec_o     = tec_q;
  assign rec_o     = rec_q;
  assign bus_off_o = bo_q;
endmodule

// File: rtl/can_fault_state.sv
module can_fault_state
  import can_fault_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             bus_off_i,
  output fault_state_e     state_o,
  output logic             warn_rise_o,
  output logic             pass_rise_o,
  output logic             bo_rise_o
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);

  logic       warn_c, pass_c;
  logic [2:0] cond_q;

  assign warn_c = (tec_i > WARN_V) || (rec_i > WARN_V);
  assign pass_c = (tec_i > PASS_V) || (rec_i > PASS_V);

  always_comb begin
    if (bus_off_i)   state_o = FS_BUSOFF;
    else if (pass_c) state_o = FS_PASSIVE;
    else if (warn_c) state_o = FS_WARN;
    else             state_o = FS_ACTIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= {bus_off_i, pass_c, warn_c};
  end

  // each transition raises its pulse independently, so all three may coincide
  assign warn_rise_o = warn_c    & ~cond_q[0];
  assign pass_rise_o = pass_c    & ~cond_q[1];
  assign bo_rise_o   = bus_off_i & ~cond_q[2];
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_fault_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] err_ev_i,
  input  logic              warn_rise_i,
  input  logic              pass_rise_i,
  input  logic              bo_rise_i,
  input  logic [WORD_W-1:0] clr_i,
  output logic [WORD_W-1:0] status_o
);
  logic [WORD_W-1:0] set_v;

  always_comb begin
    set_v = '0;
    set_v[EV_LSB +: NUM_EV] = err_ev_i;
    set_v[ST_EW] = warn_rise_i;
    set_v[ST_EP] = pass_rise_i;
    set_v[ST_BO] = bo_rise_i;
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam bit IMPL = ((b >= EV_LSB) && (b < EV_LSB + NUM_EV)) ||
                          ((b >= ST_EW) && (b <= ST_BO));
    if (IMPL) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= set_v[b] | (flag_q & ~clr_i[b]);  // set wins
      end
      assign status_o[b] = flag_q;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end

  logic unused_clr;
  assign unused_clr = ^{clr_i[WORD_W-1:EV_LSB+NUM_EV], clr_i[ST_EW-1:0]};
endmodule

// File: rtl/can_irq_route.sv
module can_irq_route
  import can_fault_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warn_rise_i,
  input  logic              pass_rise_i,
  input  logic              bo_rise_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0] clr0_i,
  input  logic [WORD_W-1:0] clr1_i,
  output logic [WORD_W-1:0] gif0_o,
  output logic [WORD_W-1:0] gif1_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  localparam int NLINE = 2;

  logic [2:0] evt;
  logic [NLINE-1:0][WORD_W-1:0] clr_a, gif_a;
  logic [NLINE-1:0] irq_a;

  assign evt = {bo_rise_i, pass_rise_i, warn_rise_i} & mask_i[IF_BOFF:IF_WARN];
  assign clr_a[0] = clr0_i;
  assign clr_a[1] = clr1_i;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [2:0] flag_q;
    logic       sel;
    assign sel = (l == 1) ? mask_i[MSK_SEL] : ~mask_i[MSK_SEL];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= '0;
      else flag_q <= (evt & {3{sel}}) | (flag_q & ~clr_a[l][IF_BOFF:IF_WARN]);
    end
    always_comb begin
      gif_a[l] = '0;
      gif_a[l][IF_BOFF:IF_WARN] = flag_q;
    end
    assign irq_a[l] = mask_i[l] & (|flag_q);
  end

  assign gif0_o = gif_a[0];
  assign gif1_o = gif_a[1];
  assign irq0_o = irq_a[MSK_L0];
  assign irq1_o = irq_a[MSK_L1];

  logic unused_bits;
  assign unused_bits = ^{mask_i[WORD_W-1:IF_BOFF+1], mask_i[IF_WARN-1:MSK_SEL+1],
                         clr0_i[WORD_W-1:IF_BOFF+1], clr0_i[IF_WARN-1:0],
                         clr1_i[WORD_W-1:IF_BOFF+1], clr1_i[IF_WARN-1:0]};
endmodule

// File: rtl/can_fault_unit.sv
module can_fault_unit
  import can_fault_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int WARN_LIM  = 96,
  parameter int PASS_LIM  = 127,
  parameter int RECOV_CNT = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tec_inc_i,
  input  logic              tec_dec_i,
  input  logic [CNT_W-1:0]  rec_inc_i,
  input  logic              rec_dec_i,
  input  logic [NUM_EV-1:0] err_ev_i,
  input  logic              recess_seq_i,
  input  logic              auto_bus_on_i,
  input  logic              reinit_i,
  input  logic [WORD_W-1:0] irq_mask_i,
  input  logic [WORD_W-1:0] stat_clr_i,
  input  logic [WORD_W-1:0] gif0_clr_i,
  input  logic [WORD_W-1:0] gif1_clr_i,
  output logic [CNT_W-1:0]  tec_o,
  output logic [CNT_W-1:0]  rec_o,
  output logic [1:0]        state_o,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] gif0_o,
  output logic [WORD_W-1:0] gif1_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  logic [CNT_W-1:0] tec_w, rec_w;
  logic             bo_w, warn_rise, pass_rise, bo_rise;
  fault_state_e     st_w;

  can_err_counters #(.CNT_W(CNT_W), .RECOV_CNT(RECOV_CNT)) u_cnt (
    .clk_i, .rst_ni,
    .tec_inc_i, .tec_dec_i, .rec_inc_i, .rec_dec_i,
    .recess_seq_i, .auto_bus_on_i, .reinit_i,
    .tec_o(tec_w), .rec_o(rec_w), .bus_off_o(bo_w)
  );

  can_fault_state #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_st (
    .clk_i, .rst_ni,
    .tec_i(tec_w), .rec_i(rec_w), .bus_off_i(bo_w),
    .state_o(st_w), .warn_rise_o(warn_rise), .pass_rise_o(pass_rise),
    .bo_rise_o(bo_rise)
  );

  can_err_status u_stat (
    .clk_i, .rst_ni, .err_ev_i,
    .warn_rise_i(warn_rise), .pass_rise_i(pass_rise), .bo_rise_i(bo_rise),
    .clr_i(stat_clr_i), .status_o
  );

  can_irq_route u_irq (
    .clk_i, .rst_ni,
    .warn_rise_i(warn_rise), .pass_rise_i(pass_rise), .bo_rise_i(bo_rise),
    .mask_i(irq_mask_i), .clr0_i(gif0_clr_i), .clr1_i(gif1_clr_i),
    .gif0_o, .gif1_o, .irq0_o, .irq1_o
  );

  assign tec_o   = tec_w;
  assign rec_o   = rec_w;
  assign state_o = st_w;
endmodule

// File: rtl/can_fault_chk.sv
module can_fault_chk #(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [5:0]       err_ev_i,
  input logic [31:0]      irq_mask_i,
  input logic [31:0]      stat_clr_i,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic [1:0]       state_o,
  input logic [31:0]      status_o,
  input logic [31:0]      gif0_o,
  input logic [31:0]      gif1_o,
  input logic             irq0_o,
  input logic             irq1_o
);
  localparam logic [CNT_W-1:0] MAXV   = '1;
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);

  p_active_below_warn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) |-> (tec_o <= WARN_V) && (rec_o <= WARN_V));

  p_bo_tec_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |-> (tec_o == MAXV));

  p_bo_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) && ($past(state_o) == 2'd3) |-> $stable(rec_o));

  p_cause_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[24] && !stat_clr_i[24] |=> status_o[24]);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev_i[0] |=> status_o[19]);

  p_route_line1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gif1_o[10]) |-> $past(irq_mask_i[2]));

  p_irq0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gif0_o[10:8]) && irq_mask_i[0] |-> irq0_o);

  p_irq1_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_mask_i[1] |-> !irq1_o);

  p_bo_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o == 2'd3) |=> status_o[18]);

  p_leave_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_o == 2'd3) |-> (tec_o == '0) && (rec_o == '0));
endmodule

bind can_fault_unit can_fault_chk #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM)) u_chk (
  .clk_i, .rst_ni, .err_ev_i, .irq_mask_i, .stat_clr_i,
  .tec_o, .rec_o, .state_o, .status_o, .gif0_o, .gif1_o, .irq0_o, .irq1_o
);

// File: tb/tb_can_fault_unit.sv
module tb_can_fault_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tec_inc = '0, rec_inc = '0;
  logic        tec_dec = 1'b0, rec_dec = 1'b0;
  logic [5:0]  err_ev = '0;
  logic        recess = 1'b0, auto_on = 1'b0, reinit = 1'b0;
  logic [31:0] mask = '0, stat_clr = '0, gif0_clr = '0, gif1_clr = '0;
  logic [7:0]  tec, rec;
  logic [1:0]  state;
  logic [31:0] status, gif0, gif1;
  logic        irq0, irq1;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tec_inc_i(tec_inc), .tec_dec_i(tec_dec), .rec_inc_i(rec_inc), .rec_dec_i(rec_dec),
    .err_ev_i(err_ev), .recess_seq_i(recess), .auto_bus_on_i(auto_on), .reinit_i(reinit),
    .irq_mask_i(mask), .stat_clr_i(stat_clr), .gif0_clr_i(gif0_clr), .gif1_clr_i(gif1_clr),
    .tec_o(tec), .rec_o(rec), .state_o(state), .status_o(status),
    .gif0_o(gif0), .gif1_o(gif1), .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    tec_inc = '0; rec_inc = '0; tec_dec = 0; rec_dec = 0; err_ev = '0;
    reinit = 0; stat_clr = '0; gif0_clr = '0; gif1_clr = '0;
  endtask

  task automatic clear_all();
    stat_clr = '1; gif0_clr = '1; gif1_clr = '1;
    tick(); quiet();
  endtask

  task automatic t_reset();
    chk("R1", "tec", 32'(tec), 0);
    chk("R1", "rec", 32'(rec), 0);
    chk("R1", "state", 32'(state), 0);
    chk("R1", "status", status, 0);
    chk("R1", "gif0|gif1", gif0 | gif1, 0);
    chk("R1", "irq", {30'd0, irq1, irq0}, 0);
  endtask

  task automatic t_count();
    rec_dec = 1; tick(); quiet();
    chk("R2", "rec dec at zero", 32'(rec), 0);
    tec_inc = 8'd50; tick(); quiet();
    chk("R2", "tec add", 32'(tec), 50);
    tec_inc = 8'd5; tec_dec = 1; tick(); quiet();
    chk("R2", "tec add and dec", 32'(tec), 54);
    tec_dec = 1; tick(); quiet();
    chk("R2", "tec dec", 32'(tec), 53);
    chk("R2", "state active", 32'(state), 0);
  endtask

  task automatic t_warn();
    mask = 32'h0000_0701;
    tec_inc = 8'd44; tick(); quiet(); tick();
    chk("R3", "state warn", 32'(state), 1);
    chk("R3", "status", status, 32'h0001_0000);
    chk("R8", "gif0 warn", gif0, 32'h0000_0100);
    chk("R9", "irq0", 32'(irq0), 1);
    gif0_clr = 32'h0000_0100; stat_clr = 32'h0001_0000; tick(); quiet(); tick();
    chk("R7", "status cleared, no re-set", status, 0);
    chk("R9", "irq0 after clear", 32'(irq0), 0);
  endtask

  task automatic t_pass_line1();
    mask = 32'h0000_0706;
    tec_inc = 8'd31; tick(); quiet(); tick();
    chk("R4", "state passive", 32'(state), 2);
    chk("R4", "status", status, 32'h0002_0000);
    chk("R8", "gif1 routed", gif1, 32'h0000_0200);
    chk("R8", "gif0 untouched", gif0, 0);
    chk("R9", "irq1/irq0", {30'd0, irq1, irq0}, 32'd2);
    clear_all();
  endtask

  task automatic t_causes();
    err_ev = 6'b101010; tick(); quiet(); tick();
    chk("R6", "cause bits", status, 32'h0150_0000);
    err_ev = 6'b000001; stat_clr = 32'h0108_0000; tick(); quiet();
    chk("R7", "set wins, other cleared", status, 32'h0058_0000);
    clear_all();
    chk("R7", "clear all", status, 0);
  endtask

  task automatic t_collide();
    reinit = 1; tick(); quiet();
    chk("R12", "reinit tec", 32'(tec), 0);
    chk("R12", "reinit state", 32'(state), 0);
    clear_all(); tick();
    mask = 32'h0000_0701;
    tec_inc = 8'd90; tick(); quiet(); tick();
    chk("R2", "tec 90", 32'(tec), 90);
    chk("R3", "no warn at 90", status, 0);
    tec_inc = 8'd200; tick(); quiet();
    chk("R5", "tec held", 32'(tec), 255);
    chk("R5", "state busoff", 32'(state), 3);
    tick();
    chk("R10", "status trio", status, 32'h0007_0000);
    chk("R10", "gif0 trio", gif0, 32'h0000_0700);
  endtask

  task automatic t_stuck();
    auto_on = 0; recess = 1; rec_inc = 8'd5; tec_dec = 1;
    repeat (200) tick();
    recess = 0; quiet();
    chk("R12", "still busoff", 32'(state), 3);
    chk("R5", "tec frozen", 32'(tec), 255);
    chk("R5", "rec frozen", 32'(rec), 0);
    reinit = 1; tick(); quiet();
    chk("R12", "reinit leaves", 32'(state), 0);
    chk("R12", "reinit zero tec", 32'(tec), 0);
    clear_all(); tick();
  endtask

  task automatic t_auto();
    mask = 32'h0000_0001;
    tec_inc = 8'd255; tick(); tick(); quiet(); tick();
    chk("R5", "busoff again", 32'(state), 3);
    chk("R5", "bo status", status[18], 1);
    chk("R8", "masked gif0", gif0, 0);
    chk("R9", "irq0 masked", 32'(irq0), 0);
    auto_on = 1; recess = 1;
    repeat (127) tick();
    chk("R11", "127 pulses", 32'(state), 3);
    tick(); recess = 0;
    chk("R11", "128 pulses leave", 32'(state), 0);
    chk("R11", "tec zero", 32'(tec), 0);
    chk("R11", "rec zero", 32'(rec), 0);
    auto_on = 0;
  endtask

  task automatic t_rec_sat();
    rec_inc = 8'd200; tick(); tick(); quiet();
    chk("R2", "rec saturate", 32'(rec), 255);
    chk("R4", "passive from rec", 32'(state), 2);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1; tick();
    t_count();
    t_warn();
    t_pass_line1();
    t_causes();
    t_collide();
    t_stuck();
    t_auto();
    t_rec_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule